// File: doc/BRIEF.md
# PCI Target I/O Write Responder

This block is a 32-bit PCI bus target that accepts single-data-phase I/O write transactions aimed at one I/O address window and passes each accepted write to a local application port. The application sees a request (address, data, byte enables) that stays up until it answers with a one-clock done pulse. Only I/O writes are handled. Reads, memory bursts, parity and configuration space belong to other blocks.

Two completion policies can be selected. In posted mode the bus transaction finishes at once and the application works on the write afterwards. In delayed mode the first attempt is answered with Retry while the write is captured and forwarded. Further attempts keep receiving Retry until the application has finished. The master's next identical attempt then completes. Every completing access is a disconnect with data on its first data phase, so a burst can never continue.

Top module: `pci_iow_target`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high (deasserted) and the application request is low.
- R2: A transaction is claimed only when C/BE# carries command 4'b0011 during the address phase and AD[31:8] equals the window base bits. DEVSEL# is first seen low at the second rising edge after the address edge (medium decode).
- R3: Any other command, or an address outside the window, leaves DEVSEL#, TRDY# and STOP# high and raises no application request.
- R4: A posted write ends its first data phase with TRDY# and STOP# low together (disconnect with data). In the same clock the application request rises, carrying the address, the data and the byte enables (app_be = ~C/BE# of the data phase).
- R5: In delayed mode, the first access of a new write is answered with STOP# low and TRDY# high (Retry), and its address, data and byte enables are still forwarded as an application request.
- R6: While the application request is outstanding, every claimed access, in either mode, is answered with Retry and leaves the request fields unchanged.
- R7: Once the application has finished a delayed write, the next access whose address, data and byte enables all match the captured write completes with disconnect with data and raises no new request. This clears the pending state, so the following delayed write is retried and captured again.
- R8: While a finished delayed write awaits its completing access, a non-matching access is retried and raises no request.
- R9: The application request and its fields stay stable until app_done is seen high. The request is low on the following clock.
- R10: A claimed transaction releases DEVSEL#, TRDY# and STOP# on the clock after the edge where FRAME# is high and IRDY# is low while STOP# is asserted.
- R11: The mode input is sampled only at the address phase. A change during a transaction does not alter how that transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Transaction framing from the master, active low |
| irdy_n | input | 1 | Master ready, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| devsel_n | output | 1 | Target claims the transaction, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target requests termination, active low |
| mode_delayed | input | 1 | 1 = delayed completion, 0 = posted |
| app_req | output | 1 | Write request to the application |
| app_addr | output | 32 | Captured I/O address |
| app_data | output | 32 | Captured write data |
| app_be | output | 4 | Captured byte enables, active high |
| app_done | input | 1 | Application has finished the request |

## Verification
The bench first targets the delayed sequence. A design that fails to capture on the first Retry would never raise a request. One that grants completion before app_done would complete the write early. One that skips the field comparison would let a different write finish the pending one, and one that keeps the pending flag would retry the next new write forever. It also sends a second posted write while the first is still outstanding. A design without that guard would overwrite the request fields. It flips the mode input in the middle of a transaction, which would turn a disconnect into a Retry if the mode were not held. Commands other than I/O write and addresses just outside the window check that no response and no request leak out.

// File: rtl/pci_iow_pkg.sv
package pci_iow_pkg;
  localparam logic [3:0] CMD_IO_WRITE = 4'b0011;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLAIM,
    ST_DATA,
    ST_TERM,
    ST_MISS
  } bus_st_t;
endpackage

// File: rtl/pci_iow_decode.sv
module pci_iow_decode #(
  parameter int          AW       = 32,
  parameter int          WIN_BITS = 8,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  localparam int         HI_W     = AW - WIN_BITS
) (
  input  logic [HI_W-1:0] ad_hi,
  input  logic [3:0]      cmd,
  output logic            hit
);
  import pci_iow_pkg::*;

  localparam logic [HI_W-1:0] BASE_HI = IO_BASE[AW-1:WIN_BITS];

  always_comb begin
    hit = (cmd == CMD_IO_WRITE) && (ad_hi == BASE_HI);
  end
endmodule

// File: rtl/pci_iow_bus_fsm.sv
module pci_iow_bus_fsm #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [AW-1:0] ad,
  input  logic          hit,
  input  logic          mode_delayed,
  input  logic          grant,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          take,
  output logic [AW-1:0] cur_addr,
  output logic          cur_delayed
);
  import pci_iow_pkg::*;

  bus_st_t       st_q, st_d;
  logic          devsel_q, devsel_d;
  logic          trdy_q, trdy_d;
  logic          stop_q, stop_d;
  logic          addr_en;
  logic [AW-1:0] addr_q;
  logic          dly_q;

  always_comb begin
    st_d     = st_q;
    devsel_d = devsel_q;
    trdy_d   = trdy_q;
    stop_d   = stop_q;
    addr_en  = 1'b0;
    take     = 1'b0;
    case (st_q)
      ST_IDLE: if (!frame_n) begin
        addr_en = 1'b1;
        st_d    = hit ? ST_CLAIM : ST_MISS;
      end
      ST_CLAIM: begin
        devsel_d = 1'b0;
        st_d     = ST_DATA;
      end
      ST_DATA: if (!irdy_n) begin
        take   = 1'b1;
        stop_d = 1'b0;
        trdy_d = !grant;
        st_d   = ST_TERM;
      end
      ST_TERM: if (frame_n && !irdy_n) begin
        devsel_d = 1'b1;
        trdy_d   = 1'b1;
        stop_d   = 1'b1;
        st_d     = ST_IDLE;
      end
      ST_MISS: if (frame_n && irdy_n) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      devsel_q <= 1'b1;
      trdy_q   <= 1'b1;
      stop_q   <= 1'b1;
      addr_q   <= '0;
      dly_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      devsel_q <= devsel_d;
      trdy_q   <= trdy_d;
      stop_q   <= stop_d;
      if (addr_en) begin
        addr_q <= ad;
        dly_q  <= mode_delayed;
      end
    end
  end

  assign devsel_n    = devsel_q;
  assign trdy_n      = trdy_q;
  assign stop_n      = stop_q;
  assign cur_addr    = addr_q;
  assign cur_delayed = dly_q;

  // R4: target ready is never offered without stop (no burst)
  p_disconnect_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !trdy_n |-> !stop_n);

  // R2: claim appears two edges after the address edge
  p_medium_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(!frame_n, 2));

  // R10: release follows the final data-phase edge
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_n && frame_n && !irdy_n) |=> (devsel_n && trdy_n && stop_n));
endmodule

// File: rtl/pci_iow_tracker.sv
module pci_iow_tracker #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [AW-1:0] cur_addr,
  input  logic          cur_delayed,
  input  logic [DW-1:0] data,
  input  logic [BW-1:0] be_n,
  input  logic          app_done,
  output logic          grant,
  output logic          app_req,
  output logic [AW-1:0] app_addr,
  output logic [DW-1:0] app_data,
  output logic [BW-1:0] app_be
);
  logic          busy_q, busy_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [BW-1:0] be_q;
  logic          match, load;

  always_comb begin
    match  = pend_q && (cur_addr == addr_q) && (data == data_q) && (~be_n == be_q);
    grant  = !busy_q && (pend_q ? match : !cur_delayed);
    load   = take && !busy_q && !pend_q;
    busy_d = busy_q;
    pend_d = pend_q;
    if (load) busy_d = 1'b1;
    else if (app_done) busy_d = 1'b0;
    if (load && cur_delayed) pend_d = 1'b1;
    else if (take && grant && pend_q) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      busy_q <= busy_d;
      pend_q <= pend_d;
      if (load) begin
        addr_q <= cur_addr;
        data_q <= data;
        be_q   <= ~be_n;
      end
    end
  end

  assign app_req  = busy_q;
  assign app_addr = addr_q;
  assign app_data = data_q;
  assign app_be   = be_q;

  // R9: request and fields hold until done
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (app_req && !app_done) |=> (app_req && $stable(app_addr) && $stable(app_data) && $stable(app_be)));

  // R9: request drops after done
  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (app_req && app_done) |=> !app_req);
endmodule

// File: rtl/pci_iow_target.sv
module pci_iow_target #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          WIN_BITS = 8,
  parameter logic [31:0] IO_BASE  = 32'h0000_1000,
  localparam int         BW       = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic [AW-1:0] ad,
  input  logic [BW-1:0] cbe_n,
  output logic          devsel_n,
  output logic          trdy_n,
  output logic          stop_n,
  input  logic          mode_delayed,
  output logic          app_req,
  output logic [AW-1:0] app_addr,
  output logic [DW-1:0] app_data,
  output logic [BW-1:0] app_be,
  input  logic          app_done
);
  logic          hit, grant, take, cur_delayed;
  logic [AW-1:0] cur_addr;

  pci_iow_decode #(.AW(AW), .WIN_BITS(WIN_BITS), .IO_BASE(IO_BASE)) u_dec (
    .ad_hi (ad[AW-1:WIN_BITS]),
    .cmd   (cbe_n),
    .hit   (hit)
  );

  pci_iow_bus_fsm #(.AW(AW)) u_fsm (
    .clk, .rst_n, .frame_n, .irdy_n, .ad, .hit, .mode_delayed, .grant,
    .devsel_n, .trdy_n, .stop_n, .take, .cur_addr, .cur_delayed
  );

  pci_iow_tracker #(.AW(AW), .DW(DW), .BW(BW)) u_trk (
    .clk, .rst_n, .take, .cur_addr, .cur_delayed,
    .data (ad[DW-1:0]), .be_n (cbe_n), .app_done,
    .grant, .app_req, .app_addr, .app_data, .app_be
  );

  // R6: an access arriving while the application is busy is retried
  p_retry_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && app_req) |=> (trdy_n && !stop_n));
endmodule

// File: tb/pci_iow_target_test.sv
module pci_iow_target_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n, irdy_n, mode_delayed, app_done;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic        devsel_n, trdy_n, stop_n, app_req;
  logic [31:0] app_addr, app_data;
  logic [3:0]  app_be;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done_all = 0;

  always #10 clk = ~clk;

  pci_iow_target uut (
    .clk, .rst_n, .frame_n, .irdy_n, .ad, .cbe_n, .devsel_n, .trdy_n, .stop_n,
    .mode_delayed, .app_req, .app_addr, .app_data, .app_be, .app_done
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one I/O transaction; returns the termination seen
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] cmd,
                           input logic [3:0] be_n, input bit flip, input bit claim,
                           output bit got_trdy, output bit got_stop);
    got_trdy = 0; got_stop = 0;
    @(negedge clk); frame_n = 1'b0; ad = a; cbe_n = cmd;
    @(posedge clk);
    @(negedge clk); frame_n = 1'b1; irdy_n = 1'b0; ad = d; cbe_n = be_n;
    if (flip) mode_delayed = ~mode_delayed;
    chk(claim ? "R2 devsel early" : "R3 devsel", {31'b0, devsel_n}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk(claim ? "R2 devsel medium" : "R3 devsel", {31'b0, devsel_n}, {31'b0, !claim});
    for (int i = 0; i < 6; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (!trdy_n || !stop_n) break;
    end
    got_trdy = !trdy_n; got_stop = !stop_n;
    if (claim) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10 release", {29'b0, devsel_n, trdy_n, stop_n}, 32'd7);
    end
    irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
    @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); app_done = 1'b1;
    @(posedge clk);
    @(negedge clk); app_done = 1'b0;
    chk("R9 request drops", {31'b0, app_req}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 outputs", {28'b0, devsel_n, trdy_n, stop_n, app_req}, 32'hE);
  endtask

  task automatic t_posted();
    bit t, s;
    mode_delayed = 1'b0;
    bus_write(32'h0000_1010, 32'hCAFE_0001, 4'b0011, 4'b0101, 0, 1, t, s);
    chk("R4 trdy", {31'b0, t}, 32'd1);
    chk("R4 stop", {31'b0, s}, 32'd1);
    chk("R4 req", {31'b0, app_req}, 32'd1);
    chk("R4 addr", app_addr, 32'h0000_1010);
    chk("R4 data", app_data, 32'hCAFE_0001);
    chk("R4 be", {28'b0, app_be}, 32'hA);
    bus_write(32'h0000_1020, 32'h1111_2222, 4'b0011, 4'b0000, 0, 1, t, s);
    chk("R6 busy retry", {30'b0, t, s}, 32'd1);
    chk("R9 data held", app_data, 32'hCAFE_0001);
    chk("R9 addr held", app_addr, 32'h0000_1010);
    pulse_done();
  endtask

  task automatic t_miss();
    bit t, s;
    bus_write(32'h0000_1010, 32'h5, 4'b0010, 4'b0000, 0, 0, t, s);
    chk("R3 wrong command", {29'b0, t, s, app_req}, 32'd0);
    bus_write(32'h0000_1100, 32'h6, 4'b0011, 4'b0000, 0, 0, t, s);
    chk("R3 outside window", {29'b0, t, s, app_req}, 32'd0);
  endtask

  task automatic t_delayed();
    bit t, s;
    mode_delayed = 1'b1;
    bus_write(32'h0000_10A4, 32'hDEAD_BEEF, 4'b0011, 4'b1100, 0, 1, t, s);
    chk("R5 retry", {30'b0, t, s}, 32'd1);
    chk("R5 req", {31'b0, app_req}, 32'd1);
    chk("R5 addr", app_addr, 32'h0000_10A4);
    chk("R5 data", app_data, 32'hDEAD_BEEF);
    chk("R5 be", {28'b0, app_be}, 32'h3);
    bus_write(32'h0000_10A4, 32'hDEAD_BEEF, 4'b0011, 4'b1100, 0, 1, t, s);
    chk("R6 retry while busy", {30'b0, t, s}, 32'd1);
    pulse_done();
    bus_write(32'h0000_10A4, 32'hDEAD_0000, 4'b0011, 4'b1100, 0, 1, t, s);
    chk("R8 mismatch retry", {30'b0, t, s}, 32'd1);
    chk("R8 no request", {31'b0, app_req}, 32'd0);
    bus_write(32'h0000_10A4, 32'hDEAD_BEEF, 4'b0011, 4'b1100, 0, 1, t, s);
    chk("R7 completes", {30'b0, t, s}, 32'd3);
    chk("R7 no new request", {31'b0, app_req}, 32'd0);
    bus_write(32'h0000_1004, 32'h0000_0042, 4'b0011, 4'b1110, 0, 1, t, s);
    chk("R7 next write retried", {30'b0, t, s}, 32'd1);
    chk("R7 next write captured", app_data, 32'h0000_0042);
    pulse_done();
    bus_write(32'h0000_1004, 32'h0000_0042, 4'b0011, 4'b1110, 0, 1, t, s);
    chk("R7 second completion", {30'b0, t, s}, 32'd3);
  endtask

  task automatic t_mode_hold();
    bit t, s;
    mode_delayed = 1'b0;
    bus_write(32'h0000_1080, 32'h7777_0000, 4'b0011, 4'b0000, 1, 1, t, s);
    chk("R11 posted kept", {30'b0, t, s}, 32'd3);
    pulse_done();
    mode_delayed = 1'b1;
    bus_write(32'h0000_1084, 32'h7777_0001, 4'b0011, 4'b0000, 1, 1, t, s);
    chk("R11 delayed kept", {30'b0, t, s}, 32'd1);
    pulse_done();
  endtask

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; ad = '0; cbe_n = 4'hF;
    mode_delayed = 1'b0; app_done = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_posted();
    t_miss();
    t_delayed();
    t_mode_hold();
    done_all = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done_all) break;
    end
    if (!done_all) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule